// File: doc/BRIEF.md
# Fractional-N Modulus Dither Controller

This block divides a fast oscillator clock by a ratio that has a fractional part. Each output period lasts either N or N+1 input cycles. A phase accumulator running modulo K decides which of the two each period uses. Over time the average ratio settles at N + num/K. The phase detector still gets one pulse per period, so it keeps comparing at the reference rate. The fineness of the frequency step is set by K alone.

The integer modulus N, the fractional numerator and the denominator K are plain control inputs. The block samples them only at a period boundary, so software or a channel-select sequencer may change them at any time. The block emits a one-cycle pulse on the last cycle of every period. It also shows the modulus in force for the current period. The pulse is a timing event, not a data word, and the phase detector cannot stall it. For that reason no output carries a valid/ready handshake and no back-pressure is defined.

Top module: `frac_mod_dither`

## Requirements
- R1: Every divide period lasts either N or N+1 cycles of `clk_i`. Throughout a period, `mod_sel_o` shows that period's length.
- R2: `div_pulse_o` is high for exactly the last cycle of each period. The distance between two successive pulses equals the `mod_sel_o` value shown during the later period.
- R3: The accumulator is zero after reset. At each boundary it adds the numerator. If the sum is K or more, it subtracts K and the next period uses N+1. Otherwise it keeps the sum and the next period uses N.
- R4: With constant inputs, any K consecutive periods contain exactly `num` periods of length N+1.
- R5: N, the numerator and K are taken only on the cycle that carries `div_pulse_o`, or on the first cycle after reset. A change at any other time leaves the running period unchanged and takes effect in the next period.
- R6: A numerator of zero makes every period last N cycles.
- R7: While reset is held, `div_pulse_o` is 0 and `mod_sel_o` is 0. The first pulse arrives N cycles after reset is released.
- R8: With N=4, num=1 and K=2, the periods alternate between 4 and 5, giving 90 cycles per 20 periods. With N=271, num=35 and K=100, exactly 35 out of 100 periods last 272 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator-side clock being divided |
| rst_ni | input | 1 | Active-low synchronous reset |
| int_mod_i | input | NW | Integer modulus N (at least 1) |
| frac_num_i | input | KW | Fractional numerator, below K |
| frac_den_i | input | KW | Resolution denominator K (at least 1) |
| div_pulse_o | output | 1 | One-cycle pulse at the end of each period |
| mod_sel_o | output | NW+1 | Modulus of the period now running |

## Verification
The assertions assume the following about the inputs: K is at least 1, the numerator is below K, N is at least 1, and K does not drop below the accumulator's current value. Under these conditions a single subtraction always keeps the accumulator in range, and every period length is either N or N+1. The directed stimulus respects these limits. It applies a reset before every scenario, so each scenario starts from an accumulator of zero. It changes inputs in the middle of a period only in the scenario that checks boundary-only sampling, and even there the numerator stays below K.

// File: rtl/fmd_pkg.sv
package fmd_pkg;
  typedef enum logic {
    SEL_BASE  = 1'b0,
    SEL_PLUS1 = 1'b1
  } mod_sel_e;
endpackage

// File: rtl/fmd_phase_acc.sv
module fmd_phase_acc #(
  parameter int KW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic [KW-1:0] num_i,
  input  logic [KW-1:0] den_i,
  output fmd_pkg::mod_sel_e sel_o
);
  localparam int SW = KW + 1;

  logic [KW-1:0] acc_q;
  logic [SW-1:0] sum;
  logic          wrap;

  always_comb begin
    sum  = {1'b0, acc_q} + {1'b0, num_i};
    wrap = (sum >= {1'b0, den_i});
  end

  assign sel_o = wrap ? fmd_pkg::SEL_PLUS1 : fmd_pkg::SEL_BASE;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (step_i) begin
      if (wrap) acc_q <= KW'(sum - {1'b0, den_i});
      else      acc_q <= KW'(sum);
    end
  end
endmodule

// File: rtl/fmd_period_cnt.sv
module fmd_period_cnt #(
  parameter int CW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == CW'(1));

  always_ff @(posedge clk_i) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= len_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/frac_mod_dither.sv
module frac_mod_dither #(
  parameter int NW = 10,
  parameter int KW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NW-1:0] int_mod_i,
  input  logic [KW-1:0] frac_num_i,
  input  logic [KW-1:0] frac_den_i,
  output logic          div_pulse_o,
  output logic [NW:0]   mod_sel_o
);
  localparam int MW = NW + 1;

  logic              running_q;
  logic              last;
  logic              boundary;
  fmd_pkg::mod_sel_e sel;
  logic [MW-1:0]     next_mod;
  logic [MW-1:0]     mod_q;

  assign boundary = !running_q || last;

  fmd_phase_acc #(.KW(KW)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (boundary),
    .num_i  (frac_num_i),
    .den_i  (frac_den_i),
    .sel_o  (sel)
  );

  always_comb begin
    next_mod = {1'b0, int_mod_i};
    if (sel == fmd_pkg::SEL_PLUS1) next_mod = next_mod + MW'(1);
  end

  fmd_period_cnt #(.CW(MW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (boundary),
    .len_i  (next_mod),
    .last_o (last)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      mod_q     <= '0;
    end else if (boundary) begin
      running_q <= 1'b1;
      mod_q     <= next_mod;
    end
  end

  assign div_pulse_o = last;
  assign mod_sel_o   = mod_q;
endmodule

// File: rtl/fmd_checker.sv
module fmd_checker #(
  parameter int NW = 10,
  parameter int KW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NW-1:0] int_mod_i,
  input logic [KW-1:0] frac_num_i,
  input logic [KW-1:0] frac_den_i,
  input logic          div_pulse_o,
  input logic [NW:0]   mod_sel_o
);
  logic          seen_q;
  logic [NW+1:0] gap_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      if (div_pulse_o) seen_q <= 1'b1;
      if (div_pulse_o)        gap_q <= (NW+2)'(1);
      else if (!(&gap_q))     gap_q <= gap_q + (NW+2)'(1);
    end
  end

  AST_MOD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_pulse_o |=> (mod_sel_o == {1'b0, $past(int_mod_i)} ||
                     mod_sel_o == {1'b0, $past(int_mod_i)} + (NW+1)'(1))); // R1

  AST_PULSE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_pulse_o && seen_q) |-> (gap_q == {1'b0, mod_sel_o})); // R2

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_pulse_o |=> (!div_pulse_o || mod_sel_o == (NW+1)'(1))); // R2

  AST_MOD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !div_pulse_o) |=> $stable(mod_sel_o)); // R5

  AST_ZERO_FRAC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_pulse_o && frac_num_i == '0) |=> (mod_sel_o == {1'b0, $past(int_mod_i)})); // R6
endmodule

bind frac_mod_dither fmd_checker #(.NW(NW), .KW(KW)) u_chk (.*);

// File: tb/sim_frac_mod_dither.sv
`timescale 1ns/1ps
module sim_frac_mod_dither;
  localparam int NW = 10;
  localparam int KW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NW-1:0] int_mod_i = '0;
  logic [KW-1:0] frac_num_i = '0;
  logic [KW-1:0] frac_den_i = 8'd1;
  logic          div_pulse_o;
  logic [NW:0]   mod_sel_o;

  int n_chk = 0;
  int n_bad = 0;
  int m_acc = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  frac_mod_dither #(.NW(NW), .KW(KW)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model_step();
    int s = m_acc + int'(frac_num_i);
    int c = (s >= int'(frac_den_i)) ? 1 : 0;
    m_acc = c ? s - int'(frac_den_i) : s;
    return int'(int_mod_i) + c;
  endfunction

  task automatic restart(input int n, input int num, input int k);
    @(negedge clk_i);
    rst_ni = 1'b0;
    int_mod_i = NW'(n); frac_num_i = KW'(num); frac_den_i = KW'(k);
    repeat (3) @(negedge clk_i);
    chk("R7 pulse in reset", int'(div_pulse_o), 0);
    chk("R7 mod in reset", int'(mod_sel_o), 0);
    m_acc = 0;
    rst_ni = 1'b1;
    begin
      int exp = model_step();
      int c = 0;
      do begin @(negedge clk_i); c++; end while (!div_pulse_o && c < 2000);
      chk("R7 first period", c, exp);
      chk("R1 first mod", int'(mod_sel_o), exp);
    end
  endtask

  // called at the negedge showing a pulse; measures the following period
  task automatic next_period(input string req, output int len,
                             input bit chg, input int n2, input int num2);
    int exp = model_step();
    int c = 0;
    do begin
      @(negedge clk_i); c++;
      if (chg && c == 2) begin int_mod_i = NW'(n2); frac_num_i = KW'(num2); end
    end while (!div_pulse_o && c < 2000);
    chk(req, c, exp);
    chk({req, " mod_sel"}, int'(mod_sel_o), exp);
    len = c;
  endtask

  task automatic t_half();
    int tot = 0, len, prev = 0;
    restart(4, 1, 2);
    for (int i = 0; i < 20; i++) begin
      next_period("R3 alternating", len, 0, 0, 0);
      if (i > 0) chk("R8 alternation", (len != prev) ? 1 : 0, 1);
      prev = len; tot += len;
    end
    chk("R8 average 4.5", tot, 90);
  endtask

  task automatic t_big();
    int hi = 0, len;
    restart(271, 35, 100);
    for (int i = 0; i < 100; i++) begin
      next_period("R1 271/35/100", len, 0, 0, 0);
      if (len == 272) hi++;
    end
    chk("R8 count of 272", hi, 35);
  endtask

  task automatic t_window();
    int hi, len;
    restart(10, 3, 7);
    for (int w = 0; w < 3; w++) begin
      hi = 0;
      for (int i = 0; i < 7; i++) begin
        next_period("R3 window", len, 0, 0, 0);
        if (len == 11) hi++;
      end
      chk("R4 window of K", hi, 3);
    end
  endtask

  task automatic t_zero();
    int len;
    restart(7, 0, 13);
    for (int i = 0; i < 15; i++) begin
      next_period("R6 zero numerator", len, 0, 0, 0);
      chk("R6 length N", len, 7);
    end
  endtask

  task automatic t_midchange();
    int len;
    restart(6, 0, 4);
    next_period("R5 before change", len, 0, 0, 0);
    next_period("R5 period during change", len, 1, 9, 2);
    chk("R5 old length kept", len, 6);
    next_period("R5 after change", len, 0, 0, 0);
    chk("R5 new N used", len, 9);
  endtask

  initial begin
    t_half();
    t_big();
    t_window();
    t_zero();
    t_midchange();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule